// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns a wide set of external interrupt inputs into per-line interrupt outputs. The lines are grouped in banks of up to 32. Each bank has its own set of control registers: an interrupt enable mask, an event mask, rising-edge and falling-edge selects, a software trigger and a pending register. Software reaches these registers through a plain single-cycle register port made of a word address, a write strobe, write data and combinational read data. The port has no handshake. A write takes effect at the clock edge where the strobe is high.

A compile-time constant per bank marks some lines as level lines. A level line passes its input straight to its output, gated by its mask bit, and never latches anything. Every other implemented line is an edge line. On an edge line, a selected edge, or a qualifying software trigger, latches a pending bit and fires a one-cycle pulse on that line's output. The inputs are taken to be synchronous to the block clock already. Edges are found by comparing each input with a registered copy of its previous level. Each bank has a parameter for its number of implemented lines. Output bit `b*32 + i` belongs to line `i` of bank `b`.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, the interrupt mask of each bank reads as that bank's level-line mask. The event mask, both edge selects, the software trigger, the pending register and the stored levels all read as zero, and every output is 0.
- R2: Bank `b` occupies word addresses `b*8` to `b*8+5`. The word offsets are 0 = interrupt mask, 1 = event mask, 2 = rising select, 3 = falling select, 4 = software trigger, 5 = pending. Offsets 6 and 7 of any bank read as zero.
- R3: A write to the interrupt mask or the event mask stores the data ANDed with the bank's implemented-line mask. A write to either edge select or to the software trigger stores the data ANDed with the edge-line mask (implemented and not level).
- R4: On an unmasked edge line, each of the following sets the pending bit and raises that output for exactly one cycle, in the cycle after the edge clock: a 0-to-1 input change with the rising select set, or a 1-to-0 change with the falling select set.
- R5: An input that holds its level causes no pending bit and no pulse, whatever the selects are.
- R6: On a line whose mask bit is 0, input changes set no pending bit and give no output. The level is still recorded, so a later unmask with no new change triggers nothing.
- R7: On a level line, the output equals the input ANDed with the line's mask bit, one clock later. A level line's pending bit stays 0.
- R8: A software trigger write stores the limited value. It sets the pending bit and pulses the output once only for a line whose written bit is 1, whose stored software bit was 0, whose mask bit is 1 and whose pending bit was 0.
- R9: Writing 1 to an edge line's pending bit clears that pending bit and the line's software trigger bit. Writing 0, or writing to a level line, leaves both unchanged.
- R10: When an edge sets a pending bit in the same cycle that a write clears it, the bit stays 1.
- R11: Lines above a bank's implemented count ignore their inputs, read as 0 in every register and drive a 0 output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_we | input | 1 | Write strobe; the write happens at this clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | NUM_BANKS*32 | Interrupt input lines, synchronous to `clk` |
| irq_out | output | NUM_BANKS*32 | Per-line interrupt outputs |

## Verification
The bench runs every implemented line in both banks through all four edge-select combinations, masked and unmasked. Level lines go through the same sweep, so a design that latched them or ignored their mask would show a wrong pending readback or a wrong output. A software-trigger sweep repeats a write of 1 onto a bit that is already set, writes 0 to pending, and clears a pending bit. These catch a design that re-fires on a stored software bit or forgets to clear that bit on a pending clear. The bench also hits a pending clear in the same cycle as a new edge, where a design that lets the clear win would drop an interrupt. It drives the unimplemented inputs high to show they never leak into outputs or readback.

// File: rtl/irq_line_pkg.sv
`timescale 1ns/1ps
package irq_line_pkg;
  localparam int WORD_W      = 32;
  localparam int BANK_STRIDE = 8;
  localparam int COUNT_W     = 6;

  typedef enum logic [2:0] {
    OFS_MASK   = 3'd0,
    OFS_EVMASK = 3'd1,
    OFS_RISE   = 3'd2,
    OFS_FALL   = 3'd3,
    OFS_SWTRIG = 3'd4,
    OFS_PEND   = 3'd5
  } reg_ofs_e;

  function automatic logic [WORD_W-1:0] lines_to_mask(input int n);
    if (n >= WORD_W) return '1;
    return (WORD_W'(1) << n) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/irq_line_edge.sv
`timescale 1ns/1ps
module irq_line_edge
  import irq_line_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] line_in,
  output logic [WORD_W-1:0] line_m,
  output logic [WORD_W-1:0] line_chg
);
  logic [WORD_W-1:0] lvl_q;

  assign line_m   = line_in & VALID;
  assign line_chg = line_m ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= line_m;
  end

  AST_LEVEL_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (lvl_q == $past(line_m))); // R5
endmodule

// File: rtl/irq_line_bank.sv
`timescale 1ns/1ps
module irq_line_bank
  import irq_line_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID  = '1,
  parameter logic [WORD_W-1:0] DIRECT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        reg_ofs,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] line_in,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] irq
);
  localparam logic [WORD_W-1:0] LVL_LINES = VALID & DIRECT;
  localparam logic [WORD_W-1:0] EDGE_LINES = VALID & ~DIRECT;

  logic [WORD_W-1:0] imr_q, emr_q, rise_q, fall_q, sw_q, pend_q, irq_q;
  logic [WORD_W-1:0] line_m, line_chg;
  logic [WORD_W-1:0] hw_set, sw_set, clr, sw_lim;
  logic sel_mask, sel_ev, sel_rise, sel_fall, sel_sw, sel_pend;

  irq_line_edge #(.VALID(VALID)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .line_m   (line_m),
    .line_chg (line_chg)
  );

  always_comb begin
    sel_mask = wr_en && (reg_ofs == OFS_MASK);
    sel_ev   = wr_en && (reg_ofs == OFS_EVMASK);
    sel_rise = wr_en && (reg_ofs == OFS_RISE);
    sel_fall = wr_en && (reg_ofs == OFS_FALL);
    sel_sw   = wr_en && (reg_ofs == OFS_SWTRIG);
    sel_pend = wr_en && (reg_ofs == OFS_PEND);
  end

  always_comb begin
    sw_lim = wdata & EDGE_LINES;
    hw_set = line_chg & imr_q & EDGE_LINES &
             ((line_m & rise_q) | (~line_m & fall_q));
    sw_set = sel_sw ? (sw_lim & ~sw_q & imr_q & ~pend_q) : '0;
    clr    = sel_pend ? (pend_q & wdata & EDGE_LINES) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= LVL_LINES;
      emr_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      sw_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      if (sel_mask) imr_q  <= wdata & VALID;
      if (sel_ev)   emr_q  <= wdata & VALID;
      if (sel_rise) rise_q <= sw_lim;
      if (sel_fall) fall_q <= sw_lim;
      if (sel_sw)   sw_q   <= sw_lim;
      else          sw_q   <= sw_q & ~clr;
      pend_q <= (pend_q & ~clr) | hw_set | sw_set;
      irq_q  <= hw_set | sw_set | (line_m & imr_q & LVL_LINES);
    end
  end

  always_comb begin
    unique case (reg_ofs)
      OFS_MASK:   rd_data = imr_q;
      OFS_EVMASK: rd_data = emr_q;
      OFS_RISE:   rd_data = rise_q;
      OFS_FALL:   rd_data = fall_q;
      OFS_SWTRIG: rd_data = sw_q;
      OFS_PEND:   rd_data = pend_q;
      default:    rd_data = '0;
    endcase
  end

  assign irq = irq_q;

  AST_PULSE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_q & EDGE_LINES & ~pend_q) == '0)); // R4
  AST_MASKED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_q & EDGE_LINES & ~$past(imr_q)) == '0)); // R6
  AST_SW_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sw |=> (sw_q == $past(sw_lim))); // R8
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pend |=> ((pend_q & $past(clr & ~hw_set)) == '0)); // R9
  AST_LEVEL_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_q & LVL_LINES) == ($past(line_m & imr_q) & LVL_LINES))); // R7
endmodule

// File: rtl/irq_line_ctrl.sv
`timescale 1ns/1ps
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*COUNT_W-1:0] BANK_LINES = {6'd8, 6'd16},
  parameter logic [NUM_BANKS*WORD_W-1:0]  LEVEL_MASK = {32'h0000_0080, 32'h0000_F000},
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = BANK_W + 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0] line_in,
  output logic [NUM_BANKS*WORD_W-1:0] irq_out
);
  localparam int SLOTS = 1 << BANK_W;

  logic [BANK_W-1:0] bank_idx;
  logic [2:0]        reg_ofs;
  logic [WORD_W-1:0] bank_rd [SLOTS];

  assign bank_idx = bus_addr[ADDR_W-1:3];
  assign reg_ofs  = bus_addr[2:0];

  for (genvar b = 0; b < SLOTS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_real
      localparam logic [WORD_W-1:0] VMASK =
        lines_to_mask(int'(BANK_LINES[b*COUNT_W +: COUNT_W]));
      logic wr_hit;
      assign wr_hit = bus_we && (bank_idx == BANK_W'(b));
      irq_line_bank #(
        .VALID  (VMASK),
        .DIRECT (LEVEL_MASK[b*WORD_W +: WORD_W])
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit),
        .reg_ofs (reg_ofs),
        .wdata   (bus_wdata),
        .line_in (line_in[b*WORD_W +: WORD_W]),
        .rd_data (bank_rd[b]),
        .irq     (irq_out[b*WORD_W +: WORD_W])
      );
    end else begin : g_empty
      assign bank_rd[b] = '0;
    end
  end

  assign bus_rdata = bank_rd[bank_idx];
endmodule

// File: tb/irq_line_ctrl_bench.sv
`timescale 1ns/1ps
module irq_line_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] line_in = '0;
  logic [63:0] irq_out;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_imr [2], m_emr [2], m_rt [2], m_ft [2];
  logic [31:0] m_sw [2], m_pr [2], m_lvl [2], m_out [2];
  logic [63:0] cur_lines = '0;

  irq_line_ctrl u_irq_line_ctrl (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .line_in (line_in), .irq_out (irq_out)
  );

  always #4 clk = ~clk;

  // bank 0: 16 lines, level lines 12..15; bank 1: 8 lines, level line 7
  function automatic logic [31:0] val(input int b);
    return (b == 0) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction
  function automatic logic [31:0] lvm(input int b);
    return (b == 0) ? 32'h0000_F000 : 32'h0000_0080;
  endfunction
  function automatic int nlines(input int b);
    return (b == 0) ? 16 : 8;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "irq_out", irq_out, {m_out[1], m_out[0]});
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      int b;
      b = a / 8;
      case (a % 8)
        0: e = m_imr[b];
        1: e = m_emr[b];
        2: e = m_rt[b];
        3: e = m_ft[b];
        4: e = m_sw[b];
        5: e = m_pr[b];
        default: e = '0;
      endcase
      bus_addr = 4'(a);
      #0.2;
      check(tag, $sformatf("readback addr %0d", a), {32'h0, bus_rdata}, {32'h0, e});
    end
  endtask

  task automatic step(input logic [63:0] lin, input logic we, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    for (int b = 0; b < 2; b++) begin
      logic [31:0] cfg, lm, chg, hw, ss, clr;
      cfg = val(b) & ~lvm(b);
      lm  = lin[b*32 +: 32] & val(b);
      chg = lm ^ m_lvl[b];
      hw  = chg & m_imr[b] & cfg & ((lm & m_rt[b]) | (~lm & m_ft[b]));
      ss  = '0;
      clr = '0;
      m_out[b] = lm & m_imr[b] & lvm(b);
      if (we && (int'(a[3]) == b)) begin
        case (a[2:0])
          3'd0: m_imr[b] = d & val(b);
          3'd1: m_emr[b] = d & val(b);
          3'd2: m_rt[b]  = d & cfg;
          3'd3: m_ft[b]  = d & cfg;
          3'd4: begin
            ss = d & cfg & ~m_sw[b] & m_imr[b] & ~m_pr[b];
            m_sw[b] = d & cfg;
          end
          3'd5: begin
            clr = m_pr[b] & d & cfg;
            m_sw[b] = m_sw[b] & ~clr;
          end
          default: ;
        endcase
      end
      m_pr[b]  = (m_pr[b] & ~clr) | hw | ss;
      m_out[b] = m_out[b] | hw | ss;
      m_lvl[b] = lm;
    end
    cur_lines = lin;
    line_in   = lin;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr(input int b, input int ofs, input logic [31:0] d, input string tag);
    step(cur_lines, 1'b1, 4'(b * 8 + ofs), d, tag);
  endtask

  task automatic lines(input logic [63:0] l, input string tag);
    step(l, 1'b0, 4'd0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_imr[b] = lvm(b); m_emr[b] = '0; m_rt[b] = '0; m_ft[b] = '0;
      m_sw[b] = '0; m_pr[b] = '0; m_lvl[b] = '0; m_out[b] = '0;
    end
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2: distinct patterns per offset show the map
    for (int b = 0; b < 2; b++) begin
      wr(b, 0, 32'h0000_1234, "R2");
      wr(b, 1, 32'h0000_00A5, "R2");
      wr(b, 2, 32'h0000_0042, "R2");
      wr(b, 3, 32'h0000_0018, "R2");
    end
    // R3: all-ones writes are trimmed per register class
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 4; o++) wr(b, o, 32'hFFFF_FFFF, "R3");
    for (int b = 0; b < 2; b++) begin
      wr(b, 4, 32'hFFFF_FFFF, "R3");
      wr(b, 5, 32'hFFFF_FFFF, "R3");
      for (int o = 1; o < 5; o++) wr(b, o, 32'h0, "R3");
    end

    // R4 / R5 / R6 / R7: edge sweep per line, select mode and mask
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < nlines(b); i++)
        for (int mode = 0; mode < 4; mode++)
          for (int msk = 0; msk < 2; msk++) begin
            string tg;
            logic [31:0] bit1;
            bit1 = 32'h1 << i;
            tg = lvm(b)[i] ? "R7" : (msk != 0 ? "R4" : "R6");
            wr(b, 0, (msk != 0) ? bit1 : 32'h0, tg);
            wr(b, 2, mode[0] ? bit1 : 32'h0, tg);
            wr(b, 3, mode[1] ? bit1 : 32'h0, tg);
            lines(64'h1 << (b * 32 + i), tg);
            lines(64'h1 << (b * 32 + i), "R5");
            lines(64'h1 << (b * 32 + i), "R5");
            lines(64'h0, tg);
            lines(64'h0, "R5");
            if (msk == 0) begin
              wr(b, 0, bit1, "R6");
              lines(64'h0, "R6");
            end
            wr(b, 5, bit1, "R9");
          end

    // R8 / R9: software trigger sweep
    for (int b = 0; b < 2; b++) begin
      wr(b, 2, 32'h0, "R8");
      wr(b, 3, 32'h0, "R8");
      for (int i = 0; i < nlines(b); i++) begin
        logic [31:0] bit1;
        bit1 = 32'h1 << i;
        wr(b, 0, val(b), "R8");
        wr(b, 4, bit1, "R8");
        wr(b, 4, bit1, "R8");
        wr(b, 5, 32'h0, "R9");
        wr(b, 5, bit1, "R9");
        wr(b, 4, bit1, "R8");
        wr(b, 4, 32'h0, "R8");
        wr(b, 4, bit1, "R8");
        wr(b, 5, ~bit1, "R9");
        wr(b, 5, bit1, "R9");
        wr(b, 0, 32'h0, "R8");
        wr(b, 4, 32'h0, "R8");
        wr(b, 4, bit1, "R8");
        wr(b, 5, val(b), "R9");
      end
    end

    // R10: edge and clear in the same cycle
    for (int b = 0; b < 2; b++) begin
      wr(b, 0, val(b), "R10");
      wr(b, 2, 32'hFFFF_FFFF, "R10");
      wr(b, 3, 32'h0, "R10");
      for (int i = 0; i < nlines(b); i++) begin
        logic [63:0] l;
        l = 64'h1 << (b * 32 + i);
        lines(l, "R10");
        lines(64'h0, "R10");
        step(l, 1'b1, 4'(b * 8 + 5), 32'h1 << i, "R10");
        lines(64'h0, "R10");
        wr(b, 5, 32'h1 << i, "R10");
      end
    end

    // R11: unimplemented inputs driven high
    for (int b = 0; b < 2; b++) begin
      wr(b, 0, 32'hFFFF_FFFF, "R11");
      wr(b, 2, 32'hFFFF_FFFF, "R11");
      wr(b, 3, 32'hFFFF_FFFF, "R11");
    end
    lines(64'hFFFF_0000_FFFF_0000 | 64'hFFFF_FF00_0000_0000, "R11");
    lines('1, "R11");
    lines('1, "R11");
    lines(64'h0, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule